// File: doc/BRIEF.md
# CRC-16/X-25 Byte Engine

This block keeps a running 16-bit frame checksum of the reflected CCITT family. The feedback polynomial is 0x8408, which is 0x1021 with its bits reversed. The register starts from all ones, and the published checksum is the register inverted. The block takes one byte in each clock cycle in which the caller raises a valid strobe. Bits enter least significant first. A synchronous clear starts a new frame.

The block serves both directions of a link. To protect outgoing bytes, the caller feeds the bytes it wants covered and reads the finished checksum, which is always present on the output. To check incoming bytes, the caller feeds the received bytes followed by the received checksum, low byte first, and looks at the match flag. The flag is high when the register holds the fixed residue that a correctly ended frame leaves behind. The caller chooses which bytes are covered and handles framing and buffering.

Top module: `crc16x25_engine`

## Requirements
- R1: After asynchronous reset the register holds 0xFFFF, so `crcOut` reads 0x0000 and `residueOk` reads 0.
- R2: When `clear` is high at a rising edge, the register returns to 0xFFFF at that edge, whatever the bytes absorbed earlier. `crcOut` then reads 0x0000.
- R3: When `dataValid` is high and `clear` is low at a rising edge, the register is updated at that edge from `dataByte`. The update equals the table step reg = T[(reg ^ byte) & 0xFF] ^ (reg >> 8), where T[1] = 0x1189. Bit 0 of the byte is consumed first. The result appears on the outputs after that edge.
- R4: `crcOut` always equals the bitwise inverse of the register. For the nine ASCII bytes "123456789" fed after a preset, it reads 0x906E.
- R5: In a cycle with both `dataValid` and `clear` low, the register, `crcOut` and `residueOk` do not change.
- R6: When `clear` and `dataValid` are high in the same cycle, the clear wins and the byte is dropped. The register becomes 0xFFFF and `crcOut` reads 0x0000.
- R7: `residueOk` is high exactly when the register holds 0xF0B8, that is when `crcOut` reads 0x0F47. This happens after any frame followed by its own checksum, low byte first.
- R8: If a frame is followed by a checksum that differs from the correct one, `residueOk` stays low after the last checksum byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart of the frame; wins over `dataValid` |
| dataValid | input | 1 | Absorb `dataByte` at this edge |
| dataByte | input | 8 | Byte to absorb, bit 0 first |
| crcOut | output | 16 | Inverted register, i.e. the finished checksum |
| residueOk | output | 1 | High when the register holds the good-frame residue |

## Verification
The clocked properties assume that `clear`, `dataValid` and `dataByte` are settled before each rising edge, and that `dataByte` carries no meaning while `dataValid` is low. The bench meets these assumptions by changing inputs only a short, fixed time after each rising edge. In that window it mixes idle cycles, clears in the middle of a frame, clears that coincide with a byte, and frames of random length. Every frame it verifies is closed by its own checksum, taken from the reference model, so the residue flag is exercised on many different byte streams.

// File: rtl/crc16x25_pkg.sv
package crc16x25_pkg;
  localparam int CRC_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] REFL_POLY = 16'h8408;
  localparam logic [CRC_W-1:0] PRESET_VAL = 16'hFFFF;
  localparam logic [CRC_W-1:0] OUT_XOR = 16'hFFFF;
  localparam logic [CRC_W-1:0] GOOD_RESIDUE = 16'hF0B8;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic preset;
    logic absorb;
  } crcStrobes_t;
endpackage

// File: rtl/crc16x25_ctrl.sv
module crc16x25_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic dataValid,
  output crc16x25_pkg::crcStrobes_t strobes
);
  import crc16x25_pkg::*;

  // The restart request wins over a byte arriving in the same cycle
  always_comb begin
    strobes.preset = clear;
    strobes.absorb = dataValid && !clear;
  end

  // The two strobes never ask for a preset and an absorb together (R6)
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.preset && strobes.absorb));
endmodule

// File: rtl/crc16x25_datapath.sv
module crc16x25_datapath #(
  parameter int DATA_W = crc16x25_pkg::BYTE_W,
  parameter int CRC_W = crc16x25_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY = crc16x25_pkg::REFL_POLY,
  parameter logic [CRC_W-1:0] INIT = crc16x25_pkg::PRESET_VAL,
  parameter logic [CRC_W-1:0] XOROUT = crc16x25_pkg::OUT_XOR,
  parameter logic [CRC_W-1:0] RESIDUE = crc16x25_pkg::GOOD_RESIDUE
) (
  input  logic clk,
  input  logic rst_n,
  input  crc16x25_pkg::crcStrobes_t strobes,
  input  logic [DATA_W-1:0] dataByte,
  output logic [CRC_W-1:0] crcOut,
  output logic residueOk
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crcReg;

  // One shift-and-conditional-xor per input bit, least significant bit first
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic feedback;
    assign feedback = stage[i][0] ^ dataByte[i];
    assign stage[i+1] = (stage[i] >> 1) ^ (feedback ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg <= INIT;
    end else if (strobes.preset) begin
      crcReg <= INIT;
    end else if (strobes.absorb) begin
      crcReg <= stage[DATA_W];
    end
  end

  assign crcOut = crcReg ^ XOROUT;
  assign residueOk = (crcReg == RESIDUE);

  // A preset strobe always leaves the register at its start value (R2)
  assert_preset_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.preset |=> crcReg == INIT);

  // Without a strobe the register holds (R5)
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.preset && !strobes.absorb) |=> $stable(crcReg));
endmodule

// File: rtl/crc16x25_engine.sv
module crc16x25_engine #(
  parameter int DATA_W = crc16x25_pkg::BYTE_W,
  parameter int CRC_W = crc16x25_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY = crc16x25_pkg::REFL_POLY,
  parameter logic [CRC_W-1:0] INIT = crc16x25_pkg::PRESET_VAL,
  parameter logic [CRC_W-1:0] XOROUT = crc16x25_pkg::OUT_XOR,
  parameter logic [CRC_W-1:0] RESIDUE = crc16x25_pkg::GOOD_RESIDUE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic dataValid,
  input  logic [DATA_W-1:0] dataByte,
  output logic [CRC_W-1:0] crcOut,
  output logic residueOk
);
  import crc16x25_pkg::*;

  localparam logic [CRC_W-1:0] EMPTY_OUT = INIT ^ XOROUT;
  localparam logic [CRC_W-1:0] GOOD_OUT = RESIDUE ^ XOROUT;

  crcStrobes_t strobes;

  crc16x25_ctrl u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .clear(clear),
    .dataValid(dataValid),
    .strobes(strobes)
  );

  crc16x25_datapath #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY),
    .INIT(INIT), .XOROUT(XOROUT), .RESIDUE(RESIDUE)
  ) u_datapath (
    .clk(clk),
    .rst_n(rst_n),
    .strobes(strobes),
    .dataByte(dataByte),
    .crcOut(crcOut),
    .residueOk(residueOk)
  );

  // A clear coinciding with a byte yields the empty-frame checksum (R6)
  assert_clear_beats_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && dataValid) |=> crcOut == EMPTY_OUT);

  // Idle inputs leave the published checksum unchanged (R5)
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !dataValid) |=> $stable(crcOut) && $stable(residueOk));

  // The match flag only accompanies the good-frame checksum value (R7)
  assert_flag_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    residueOk |-> crcOut == GOOD_OUT);
endmodule

// File: tb/crc16x25_engine_test.sv
module crc16x25_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic dataValid = 1'b0;
  logic [7:0] dataByte = 8'h00;
  logic [15:0] crcOut;
  logic residueOk;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [15:0] table16 [256];
  logic [15:0] refReg;

  always #10 clk = ~clk;

  crc16x25_engine uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .dataValid(dataValid),
    .dataByte(dataByte), .crcOut(crcOut), .residueOk(residueOk)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [15:0] c;
      c = 16'(i);
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      table16[i] = c;
    end
  end

  // Behavioural reference of the register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) refReg <= 16'hFFFF;
    else if (clear) refReg <= 16'hFFFF;
    else if (dataValid) refReg <= table16[(refReg ^ {8'h00, dataByte}) & 16'h00FF] ^ (refReg >> 8);
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3/R4 crcOut", crcOut, ~refReg);
      check("R7 residueOk", {15'd0, residueOk}, {15'd0, refReg == 16'hF0B8});
    end
  end

  task automatic sendByte(input logic [7:0] b);
    @(posedge clk); #2;
    clear = 1'b0; dataValid = 1'b1; dataByte = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      clear = 1'b0; dataValid = 1'b0; dataByte = 8'h00;
    end
    @(negedge clk);
  endtask

  task automatic doClear(input logic withData, input logic [7:0] b);
    @(posedge clk); #2;
    clear = 1'b1; dataValid = withData; dataByte = b;
  endtask

  task automatic sendDigits();
    for (int i = 0; i < 9; i++) sendByte(8'h31 + 8'(i));
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] snap;
    logic [15:0] fcs;
    #45 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 crcOut after reset", crcOut, 16'h0000);
    check("R1 residueOk after reset", {15'd0, residueOk}, 16'h0000);

    // R4 standard check string
    sendDigits();
    idle(1);
    check("R4 check value", crcOut, 16'h906E);

    // R7 append checksum low byte first
    sendByte(8'h6E); sendByte(8'h90);
    idle(1);
    check("R7 residue flag", {15'd0, residueOk}, 16'h0001);
    check("R7 residue output", crcOut, 16'h0F47);

    // R5 idle cycles keep everything
    snap = crcOut;
    idle(5);
    check("R5 idle hold", crcOut, snap);

    // R6 clear with a byte in the same cycle
    sendByte(8'h12);
    doClear(1'b1, 8'hA5);
    idle(1);
    check("R6 clear priority", crcOut, 16'h0000);

    // R3 single byte after preset, via table form (T[1]=0x1189)
    check("R3 table entry", table16[1], 16'h1189);
    sendByte(8'h01);
    idle(1);
    check("R3 single byte", crcOut, ~(table16[8'hFE] ^ 16'h00FF));

    // R2 clear in the middle of a frame, then the string again
    doClear(1'b0, 8'h00);
    sendByte(8'h55); sendByte(8'hAA);
    doClear(1'b0, 8'h00);
    idle(1);
    check("R2 mid-frame clear", crcOut, 16'h0000);
    sendDigits();
    idle(1);
    check("R2 restart check value", crcOut, 16'h906E);

    // R8 wrong checksum byte
    sendByte(8'h6F); sendByte(8'h90);
    idle(1);
    check("R8 bad checksum flag", {15'd0, residueOk}, 16'h0000);

    // Random frames, each closed by its own checksum
    for (int f = 0; f < 60; f++) begin
      int len;
      doClear(1'($urandom_range(0, 1)), 8'($urandom));
      len = $urandom_range(1, 24);
      for (int j = 0; j < len; j++) begin
        sendByte(8'($urandom));
        if ($urandom_range(0, 3) == 0) idle(1);
      end
      idle(1);
      fcs = ~refReg;
      sendByte(fcs[7:0]);
      sendByte(fcs[15:8]);
      idle(1);
      check("R7 random frame flag", {15'd0, residueOk}, 16'h0001);
    end

    // Random mix of clear, valid and idle
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk); #2;
      clear = ($urandom_range(0, 15) == 0);
      dataValid = 1'($urandom_range(0, 1));
      dataByte = 8'($urandom);
    end
    idle(1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule